// File: doc/BRIEF.md
# Floating-Point to Signed Integer Truncating Converter

This block takes one IEEE 754 binary128 operand (1 sign bit, 15 exponent bits, 112 fraction bits) and converts it to a signed 128-bit two's-complement integer. The conversion always rounds toward zero by dropping the fractional part. The widths of the exponent, the fraction and the integer are parameters. The default is the binary128 to 128-bit case. Smaller settings, such as binary16 to 8-bit, behave by the same rules.

Every conversion is fully classified. NaNs, infinities and magnitudes beyond the integer range saturate to one of the two integer limits and raise an invalid-conversion flag. A signaling NaN also raises a separate signaling-NaN flag. A value with a discarded non-zero fraction raises an inexact flag and an inexact exception flag. The fraction-rounded flag is always low.

The data path is a plain valid-qualified stream without back-pressure. The block accepts an operand in every cycle that `in_valid` is high. It presents the result and all flags, registered, with a one-cycle `out_valid` pulse on the next clock. The outputs hold until the next accepted operand. A synchronous reset clears them.

Top module: `fp_to_int_trunc`

## Requirements
- R1: For a finite input whose truncated value lies within [MIN, MAX] (MIN = -2^(INT_W-1), MAX = 2^(INT_W-1)-1), the result is that value truncated toward zero. `out_inexact` and `out_inexact_exc` are both 1 exactly when the discarded fraction is non-zero.
- R2: A quiet NaN (all exponent bits 1, fraction non-zero, fraction MSB 1) gives MIN with `out_invalid`=1, `out_snan_inv`=0 and both inexact flags 0.
- R3: A signaling NaN (all exponent bits 1, fraction non-zero, fraction MSB 0) gives MIN with `out_invalid`=1, `out_snan_inv`=1 and both inexact flags 0.
- R4: An input at or below MIN-1, including negative infinity (all exponent bits 1, fraction 0, sign 1), gives MIN with `out_invalid`=1 and both inexact flags 0.
- R5: An input at or above MAX+1, including positive infinity, gives MAX with `out_invalid`=1 and both inexact flags 0.
- R6: An input strictly between MIN-1 and MIN gives MIN with `out_invalid`=0 and both inexact flags 1.
- R7: An input strictly between MAX and MAX+1 gives MAX with `out_invalid`=0 and both inexact flags 1.
- R8: A zero of either sign gives 0 with no flags. A non-zero subnormal (exponent field 0) gives 0 with both inexact flags 1.
- R9: `out_rounded` is 0 on every conversion. Whenever `out_invalid` is 1, both inexact flags are 0.
- R10: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. The result and flags change only on an accepted operand. Reset clears every output to 0.
- R11: The operand is read as sign in the MSB, then EXP_W exponent bits, then FRAC_W fraction bits. The exponent bias is 2^(EXP_W-1)-1, and normal numbers carry an implicit leading one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 1+EXP_W+FRAC_W | Floating-point operand |
| out_valid | output | 1 | One-cycle pulse: result valid |
| out_data | output | INT_W | Signed integer result |
| out_rounded | output | 1 | Fraction-rounded flag (always 0) |
| out_inexact | output | 1 | Discarded fraction was non-zero |
| out_inexact_exc | output | 1 | Sticky inexact exception request |
| out_invalid | output | 1 | Invalid conversion (NaN, infinity, out of range) |
| out_snan_inv | output | 1 | Invalid because of a signaling NaN |

## Verification
The assertions check the following on every cycle:
- the one-cycle latency and the idle cycles of `out_valid`;
- that the outputs hold between accepted operands;
- that the rounded flag stays low;
- that invalid results are exact and saturated to a limit;
- that a signaling-NaN flag always comes with the invalid flag;
- that both inexact flags agree.

Only the bench's scenarios can show that each value maps to the correct integer and class. For this, every binary16 pattern is swept through an 8-bit configuration. This sweep reaches both in-between bands next to the limits and the exact MIN boundary. Directed binary128 operands then confirm that the same rules hold at full width near 2^127.

// File: rtl/fpti_pkg.sv
package fpti_pkg;

  // Operand class, exactly one bit set per operand
  typedef struct packed {
    logic is_zero;
    logic is_sub;
    logic is_norm;
    logic is_inf;
    logic is_qnan;
    logic is_snan;
  } fp_kind_t;

endpackage

// File: rtl/fpti_classify.sv
module fpti_classify
  import fpti_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic [FP_W-1:0]   op,
  output logic              sign,
  output fp_kind_t          kind,
  output logic [EXP_W-1:0]  exp_f,
  output logic [FRAC_W:0]   mant
);

  logic [FRAC_W-1:0] frac;
  logic exp_ones, exp_none, frac_any;

  // R11: sign | exponent | fraction, MSB first
  assign sign  = op[FP_W-1];
  assign exp_f = op[FP_W-2 -: EXP_W];
  assign frac  = op[FRAC_W-1:0];

  assign exp_ones = &exp_f;
  assign exp_none = ~|exp_f;
  assign frac_any = |frac;

  always_comb begin
    kind         = '0;
    kind.is_zero = exp_none & ~frac_any;
    kind.is_sub  = exp_none & frac_any;
    kind.is_norm = ~exp_none & ~exp_ones;
    kind.is_inf  = exp_ones & ~frac_any;
    kind.is_qnan = exp_ones & frac_any & frac[FRAC_W-1];
    kind.is_snan = exp_ones & frac_any & ~frac[FRAC_W-1];
  end

  // implicit leading one only for normal numbers
  assign mant = {~exp_none, frac};

endmodule

// File: rtl/fpti_align.sv
module fpti_align #(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int INT_W  = 128
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W:0]   mant,
  output logic [INT_W-1:0]  int_mag,
  output logic              frac_nz,
  output logic              huge
);

  localparam int EU_W  = EXP_W + 2;
  localparam int SHW   = $clog2(INT_W);
  localparam int EXT_W = FRAC_W + INT_W;
  localparam logic signed [EU_W-1:0] BIAS_S  = EU_W'((2 ** (EXP_W - 1)) - 1);
  localparam logic signed [EU_W-1:0] INT_LIM = EU_W'(INT_W);

  logic signed [EU_W-1:0] e_unb;
  logic                   tiny;
  logic [SHW-1:0]         amt;
  logic [EXT_W-1:0]       stage [SHW+1];

  assign e_unb = $signed({2'b00, exp_f}) - BIAS_S;
  assign tiny  = e_unb[EU_W-1];
  // magnitude reaches 2^INT_W or more: out of any signed range
  assign huge  = (e_unb >= INT_LIM);
  assign amt   = (tiny || huge) ? '0 : e_unb[SHW-1:0];

  // logarithmic left shifter: the binary point sits at bit FRAC_W
  assign stage[0] = {{(INT_W-1){1'b0}}, mant};
  for (genvar i = 0; i < SHW; i++) begin : g_shift
    assign stage[i+1] = amt[i] ? (stage[i] << (1 << i)) : stage[i];
  end

  assign int_mag = tiny ? '0 : stage[SHW][FRAC_W +: INT_W];
  assign frac_nz = tiny ? (|mant) : (|stage[SHW][FRAC_W-1:0]);

endmodule

// File: rtl/fpti_resolve.sv
module fpti_resolve
  import fpti_pkg::*;
#(
  parameter int INT_W = 128
) (
  input  logic              sign,
  input  fp_kind_t          kind,
  input  logic [INT_W-1:0]  int_mag,
  input  logic              frac_nz,
  input  logic              huge,
  output logic [INT_W-1:0]  res,
  output logic              inexact,
  output logic              invalid,
  output logic              snan_inv
);

  localparam logic [INT_W-1:0] MIN_V = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_V = ~MIN_V;

  always_comb begin
    res      = '0;
    inexact  = 1'b0;
    invalid  = 1'b0;
    snan_inv = 1'b0;
    if (kind.is_qnan || kind.is_snan) begin
      invalid  = 1'b1;
      snan_inv = kind.is_snan;
      res      = MIN_V;
    end else if (kind.is_inf) begin
      invalid = 1'b1;
      res     = sign ? MIN_V : MAX_V;
    end else if (kind.is_sub) begin
      inexact = 1'b1;
    end else if (kind.is_norm) begin
      if (huge) begin
        invalid = 1'b1;
        res     = sign ? MIN_V : MAX_V;
      end else if (!sign) begin
        if (int_mag[INT_W-1]) begin
          invalid = 1'b1;
          res     = MAX_V;
        end else begin
          res     = int_mag;
          inexact = frac_nz;
        end
      end else begin
        if (int_mag > MIN_V) begin
          invalid = 1'b1;
          res     = MIN_V;
        end else begin
          // int_mag == 2^(INT_W-1) negates to MIN itself
          res     = '0 - int_mag;
          inexact = frac_nz;
        end
      end
    end
  end

endmodule

// File: rtl/fp_to_int_trunc.sv
module fp_to_int_trunc
  import fpti_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 112,
  parameter int INT_W  = 128,
  localparam int FP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FP_W-1:0]   in_data,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_data,
  output logic              out_rounded,
  output logic              out_inexact,
  output logic              out_inexact_exc,
  output logic              out_invalid,
  output logic              out_snan_inv
);

  localparam logic [INT_W-1:0] MIN_V = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_V = ~MIN_V;

  logic              c_sign;
  fp_kind_t          c_kind;
  logic [EXP_W-1:0]  c_exp;
  logic [FRAC_W:0]   c_mant;
  logic [INT_W-1:0]  a_mag;
  logic              a_fnz, a_huge;
  logic [INT_W-1:0]  r_res;
  logic              r_inx, r_inv, r_snan;

  fpti_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
    .op(in_data), .sign(c_sign), .kind(c_kind), .exp_f(c_exp), .mant(c_mant)
  );

  fpti_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_aln (
    .exp_f(c_exp), .mant(c_mant), .int_mag(a_mag), .frac_nz(a_fnz), .huge(a_huge)
  );

  fpti_resolve #(.INT_W(INT_W)) u_res (
    .sign(c_sign), .kind(c_kind), .int_mag(a_mag), .frac_nz(a_fnz), .huge(a_huge),
    .res(r_res), .inexact(r_inx), .invalid(r_inv), .snan_inv(r_snan)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid       <= 1'b0;
      out_data        <= '0;
      out_rounded     <= 1'b0;
      out_inexact     <= 1'b0;
      out_inexact_exc <= 1'b0;
      out_invalid     <= 1'b0;
      out_snan_inv    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data        <= r_res;
        out_rounded     <= 1'b0;
        out_inexact     <= r_inx;
        out_inexact_exc <= r_inx;
        out_invalid     <= r_inv;
        out_snan_inv    <= r_snan;
      end
    end
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_invalid) && $stable(out_inexact)));
  // R9
  rounded_low_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_rounded);
  // R9
  invalid_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (!out_inexact && !out_inexact_exc));
  // R1
  inexact_pair_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_inexact_exc == out_inexact));
  // R3
  snan_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_snan_inv) |-> (out_invalid && out_data == MIN_V));
  // R4 / R5
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> (out_data == MIN_V || out_data == MAX_V));

endmodule

// File: tb/fp_to_int_trunc_tb_top.sv
`timescale 1ns/1ps
module fp_to_int_trunc_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // small configuration: binary16 -> int8
  logic        s_in_valid = 1'b0;
  logic [15:0] s_in_data  = '0;
  logic        s_out_valid, s_rnd, s_inx, s_exc, s_inv, s_sn;
  logic [7:0]  s_out_data;

  // default configuration: binary128 -> int128
  logic         w_in_valid = 1'b0;
  logic [127:0] w_in_data  = '0;
  logic         w_out_valid, w_rnd, w_inx, w_exc, w_inv, w_sn;
  logic [127:0] w_out_data;

  fp_to_int_trunc #(.EXP_W(5), .FRAC_W(10), .INT_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(s_in_valid), .in_data(s_in_data),
    .out_valid(s_out_valid), .out_data(s_out_data), .out_rounded(s_rnd),
    .out_inexact(s_inx), .out_inexact_exc(s_exc), .out_invalid(s_inv),
    .out_snan_inv(s_sn)
  );

  fp_to_int_trunc dut_wide_i (
    .clk(clk), .rst(rst), .in_valid(w_in_valid), .in_data(w_in_data),
    .out_valid(w_out_valid), .out_data(w_out_data), .out_rounded(w_rnd),
    .out_inexact(w_inx), .out_inexact_exc(w_exc), .out_invalid(w_inv),
    .out_snan_inv(w_sn)
  );

  task automatic check(input string tag, input logic [132:0] act, input logic [132:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent arithmetic model for the 16-bit format
  task automatic check_small(input logic [15:0] x);
    logic [7:0] r;
    logic inx, inv, sn;
    string tag;
    real v;
    int t;
    int e;
    int f;
    r = '0; inx = 0; inv = 0; sn = 0; tag = "R1";
    e = int'(x[14:10]);
    f = int'(x[9:0]);
    if (e == 31) begin
      inv = 1;
      if (f != 0) begin
        sn = !x[9]; r = 8'h80; tag = sn ? "R3" : "R2";
      end else begin
        r = x[15] ? 8'h80 : 8'h7F; tag = x[15] ? "R4" : "R5";
      end
    end else begin
      if (e == 0) v = real'(f);
      else v = real'(1024 + f);
      for (int k = 0; k < ((e == 0) ? 24 : 25); k++) v = v / 2.0;
      for (int k = 0; k < ((e == 0) ? 0 : e); k++) v = v * 2.0;
      if (x[15]) v = -v;
      if (e == 0) tag = "R8";
      if (v >= 128.0) begin
        inv = 1; r = 8'h7F; tag = "R5";
      end else if (v <= -129.0) begin
        inv = 1; r = 8'h80; tag = "R4";
      end else if (v < -128.0) begin
        r = 8'h80; inx = 1; tag = "R6";
      end else if (v > 127.0) begin
        r = 8'h7F; inx = 1; tag = "R7";
      end else begin
        t = $rtoi(v);
        r = t[7:0];
        inx = ($itor(t) != v);
      end
    end
    check({tag, " small"},
          133'({s_out_valid, s_out_data, s_inx, s_exc, s_inv, s_sn, s_rnd}),
          133'({1'b1, r, inx, inx, inv, sn, 1'b0}));
  endtask

  task automatic wide_case(input string tag, input logic [127:0] x,
                           input logic [127:0] r, input logic inx,
                           input logic inv, input logic sn);
    @(negedge clk);
    w_in_valid = 1'b1;
    w_in_data  = x;
    @(negedge clk);
    w_in_valid = 1'b0;
    check({tag, " wide"},
          133'({w_out_valid, w_out_data, w_inx, w_exc, w_inv, w_sn}),
          133'({1'b1, r, inx, inx, inv, sn}));
    check("R9 rounded", 133'(w_rnd), 133'(0));
  endtask

  function automatic logic [127:0] fp128(input logic s, input logic [14:0] e,
                                         input logic [111:0] f);
    return {s, e, f};
  endfunction

  localparam logic [127:0] WMIN = {1'b1, 127'b0};
  localparam logic [127:0] WMAX = ~WMIN;

  initial begin
    logic [15:0] prev;
    prev = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset small",
          133'({s_out_valid, s_out_data, s_inx, s_exc, s_inv, s_sn, s_rnd}), 133'(0));
    check("R10 reset wide",
          133'({w_out_valid, w_out_data, w_inx, w_exc, w_inv, w_sn, w_rnd}), 133'(0));
    rst = 1'b0;

    // exhaustive sweep, one operand per cycle
    for (int k = 0; k < 65536; k++) begin
      @(negedge clk);
      if (k > 0) check_small(prev);
      s_in_valid = 1'b1;
      s_in_data  = k[15:0];
      prev       = k[15:0];
    end
    @(negedge clk);
    check_small(prev);
    s_in_valid = 1'b0;
    s_in_data  = 16'h3C00;  // 1.0 offered while not valid
    @(negedge clk);
    // R10: no pulse and the outputs hold the last result (0xFFFF is a NaN)
    check("R10 idle small",
          133'({s_out_valid, s_out_data, s_inv, s_sn}), 133'({1'b0, 8'h80, 1'b1, 1'b0}));

    // full-width directed cases; bias 16383 = 15'h3FFF (R11 layout)
    wide_case("R11 1.5", fp128(0, 15'h3FFF, {1'b1, 111'b0}), 128'd1, 1, 0, 0);
    wide_case("R11 -1.0", fp128(1, 15'h3FFF, '0), '1, 0, 0, 0);
    wide_case("R1 -2^127 exact", fp128(1, 15'h407E, '0), WMIN, 0, 0, 0);
    wide_case("R1 near max", fp128(0, 15'h407D, '1),
              (128'd1 << 127) - (128'd1 << 14), 0, 0, 0);
    wide_case("R1 2^-1", fp128(1, 15'h3FFE, '0), '0, 1, 0, 0);
    wide_case("R5 2^127", fp128(0, 15'h407E, '0), WMAX, 0, 1, 0);
    wide_case("R4 below min", fp128(1, 15'h407E, 112'd1), WMIN, 0, 1, 0);
    wide_case("R4 -inf", fp128(1, 15'h7FFF, '0), WMIN, 0, 1, 0);
    wide_case("R5 +inf", fp128(0, 15'h7FFF, '0), WMAX, 0, 1, 0);
    wide_case("R5 huge", fp128(0, 15'h7FFE, 112'd5), WMAX, 0, 1, 0);
    wide_case("R2 qnan", fp128(0, 15'h7FFF, {1'b1, 111'd3}), WMIN, 0, 1, 0);
    wide_case("R3 snan", fp128(1, 15'h7FFF, 112'd1), WMIN, 0, 1, 1);
    wide_case("R8 -0", fp128(1, 15'h0000, '0), '0, 0, 0, 0);
    wide_case("R8 subnormal", fp128(0, 15'h0000, 112'd1), '0, 1, 0, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #1_900_000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule